// File: doc/BRIEF.md
# Interlaced Vertical Sync and Field Generator

This block produces the vertical timing outputs for an interlaced standard-definition video stream. It owns a pixel-clock horizontal counter and a line counter, and their lengths follow the chosen standard: 525 or 625 lines, and a line total set by the standard and by whether square-pixel sampling is used. From these counters it derives a registered line sync (`hs_n_o`), a vertical sync (`vs_o`), a field flag (`field_o`) and one shared output that carries either vertical sync or field.

The vertical sync pulse starts and stops on configured lines of the first field. The same lines, moved by half a frame, are used in the second field. For each field separately, and for the start and stop edges separately, a control bit places the edge either at the line-start point or half an active line later. The line-start point is measured from either the falling or the rising edge of the line sync. The sync polarity can be inverted. All configuration and line numbers are sampled into shadow registers at field boundaries only, so a change made mid-field cannot produce a runt pulse.

Top module: `vsf_gen`

## Requirements
- R1: The horizontal counter wraps after H_TOT_NTSC, H_TOT_NTSC_SQ, H_TOT_PAL or H_TOT_PAL_SQ pixels, chosen by `std_pal_i` (1 = 625 lines) and `sq_pix_i`. The line counter runs from 1 to 525 or 625. `hs_n_o` is low for the first HS_W pixels of each line.
- R2: Raw field is 1 on lines 1-3 and 266-525 for the 525-line standard, and on lines 313-625 for the 625-line standard. `field_o` changes only on the first pixel of a boundary line (4/266 or 1/313), or one pixel later when the gate opens.
- R3: `field_o` is held at 0 until two field boundaries have been counted after reset. It follows the raw field from the pixel after the second boundary.
- R4: Bit 0 of `vs_beg_ls_i` sets the start edge in the first field (field 0). A value of 1 starts vertical sync at the line-start point of the configured begin line. A value of 0 starts it at the mid-line point.
- R5: Bit 1 of `vs_beg_ls_i` sets the start edge in the same way for the second field.
- R6: Bit 0 of `vs_end_ls_i` sets where vertical sync ends in the first field: 1 for line start, 0 for mid-line.
- R7: Bit 1 of `vs_end_ls_i` sets where vertical sync ends in the second field in the same way.
- R8: The line-start point is pixel 0 (the line sync falling edge) when `ref_hsb_i` = 1, and pixel HS_W (the rising edge) when it is 0. The mid-line point is that reference plus half the active length of the selected mode.
- R9: `vs_o` is active high when `vs_act_low_i` = 0 and active low when it is 1.
- R10: `shared_o` carries `field_o` when `shared_vs_i` = 0 and `vs_o` when it is 1.
- R11: All configuration inputs and line numbers are sampled only on the first pixel of a field-boundary line (and during reset). A change made at any other time has no effect until the next boundary.
- R12: While reset is held, `vs_o` sits at its inactive level for the applied polarity and `field_o` is 0.
- R13: The line numbers for the second field are the first-field numbers plus 262 (525-line) or 312 (625-line), wrapped past the last line back to line 1. Begin and end lines are taken from the inputs of the selected standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_pal_i | input | 1 | 1 = 625-line standard, 0 = 525-line |
| sq_pix_i | input | 1 | Square-pixel line timing select |
| vs_beg_ls_i | input | 2 | Start-edge placement, [0] first field, [1] second field (1 = line start) |
| vs_end_ls_i | input | 2 | End-edge placement, [0] first field, [1] second field (1 = line start) |
| ref_hsb_i | input | 1 | Line-start reference: 1 = sync falling edge, 0 = rising edge |
| vs_act_low_i | input | 1 | Vertical sync polarity, 1 = active low |
| shared_vs_i | input | 1 | Shared output select, 1 = vertical sync |
| ntsc_vs_beg_i | input | LW | Begin line, 525-line standard |
| ntsc_vs_end_i | input | LW | End line, 525-line standard |
| pal_vs_beg_i | input | LW | Begin line, 625-line standard |
| pal_vs_end_i | input | LW | End line, 625-line standard |
| hs_n_o | output | 1 | Registered line sync, active low |
| vs_o | output | 1 | Registered vertical sync |
| field_o | output | 1 | Registered field flag |
| shared_o | output | 1 | Registered shared sync/field output |

## Verification
Five configurations are run against a cycle-level model of the requirements. They cover both standards in both pixel modes, all four mixes of line-start and mid-line placement for the two edges, both line-start references and both polarities. Two of the runs cover a whole frame, which separates a correct line count and field toggle from an off-by-one wrap. A run whose begin line sits near the frame end pushes the second-field pulse past the last line, which exposes a missing wrap. A directed run changes the polarity and the shared-output select in mid-field, then shows that nothing moves before the next boundary and that both changes apply after it.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
   localparam int NTSC_LINES = 525;
   localparam int PAL_LINES  = 625;
   localparam int NTSC_TOG0  = 4;
   localparam int NTSC_TOG1  = 266;
   localparam int PAL_TOG0   = 1;
   localparam int PAL_TOG1   = 313;
   localparam int NTSC_HALF  = 262;
   localparam int PAL_HALF   = 312;

   typedef struct packed {
      logic       pal;
      logic       sqp;
      logic [1:0] beg_ls;
      logic [1:0] end_ls;
      logic       ref_hsb;
      logic       vs_low;
      logic       sh_vs;
   } vsf_cfg_t;
endpackage

// File: rtl/vsf_line_timer.sv
module vsf_line_timer import vsf_pkg::*; #(
   parameter int HW            = 10,
   parameter int LW            = 10,
   parameter int H_TOT_NTSC    = 858,
   parameter int H_TOT_NTSC_SQ = 780,
   parameter int H_TOT_PAL     = 864,
   parameter int H_TOT_PAL_SQ  = 944
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pal,
   input  logic          sqp,
   output logic [HW-1:0] h,
   output logic [LW-1:0] line
);
   logic [HW-1:0] h_last;
   logic [LW-1:0] l_last;

   always_comb begin
      unique case ({pal, sqp})
         2'b00:   h_last = HW'(H_TOT_NTSC - 1);
         2'b01:   h_last = HW'(H_TOT_NTSC_SQ - 1);
         2'b10:   h_last = HW'(H_TOT_PAL - 1);
         default: h_last = HW'(H_TOT_PAL_SQ - 1);
      endcase
      l_last = pal ? LW'(PAL_LINES) : LW'(NTSC_LINES);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h    <= '0;
         line <= LW'(1);
      end else if (h == h_last) begin
         h    <= '0;
         line <= (line == l_last) ? LW'(1) : line + LW'(1);
      end else begin
         h <= h + HW'(1);
      end
   end
endmodule

// File: rtl/vsf_edge_sched.sv
module vsf_edge_sched import vsf_pkg::*; #(
   parameter int HW            = 10,
   parameter int LW            = 10,
   parameter int HS_W          = 64,
   parameter int H_ACT_NTSC    = 720,
   parameter int H_ACT_NTSC_SQ = 640,
   parameter int H_ACT_PAL     = 720,
   parameter int H_ACT_PAL_SQ  = 768
) (
   input  logic [HW-1:0] h,
   input  logic [LW-1:0] line,
   input  vsf_cfg_t      cfg,
   input  logic [LW-1:0] beg_line,
   input  logic [LW-1:0] end_line,
   output logic          ev_beg,
   output logic          ev_end,
   output logic          raw_field,
   output logic          at_bnd
);
   logic [HW-1:0] act_half, ref_pos, mid_pos;
   logic [LW:0]   half, lines;
   logic [1:0]    hit_b, hit_e;

   always_comb begin
      unique case ({cfg.pal, cfg.sqp})
         2'b00:   act_half = HW'(H_ACT_NTSC / 2);
         2'b01:   act_half = HW'(H_ACT_NTSC_SQ / 2);
         2'b10:   act_half = HW'(H_ACT_PAL / 2);
         default: act_half = HW'(H_ACT_PAL_SQ / 2);
      endcase
      ref_pos = cfg.ref_hsb ? '0 : HW'(HS_W);
      mid_pos = ref_pos + act_half;
      half    = cfg.pal ? (LW+1)'(PAL_HALF)  : (LW+1)'(NTSC_HALF);
      lines   = cfg.pal ? (LW+1)'(PAL_LINES) : (LW+1)'(NTSC_LINES);
   end

   // one edge detector per field: f = 0 first field, f = 1 second field
   for (genvar f = 0; f < 2; f++) begin : g_fld
      logic [LW:0]   b_sum, e_sum;
      logic [LW-1:0] b_ln, e_ln;
      logic [HW-1:0] b_pos, e_pos;
      always_comb begin
         b_sum = {1'b0, beg_line} + ((f == 1) ? half : '0);
         e_sum = {1'b0, end_line} + ((f == 1) ? half : '0);
         b_ln  = (b_sum > lines) ? LW'(b_sum - lines) : LW'(b_sum);
         e_ln  = (e_sum > lines) ? LW'(e_sum - lines) : LW'(e_sum);
         b_pos = cfg.beg_ls[f] ? ref_pos : mid_pos;
         e_pos = cfg.end_ls[f] ? ref_pos : mid_pos;
      end
      assign hit_b[f] = (line == b_ln) && (h == b_pos);
      assign hit_e[f] = (line == e_ln) && (h == e_pos);
   end

   assign ev_beg = |hit_b;
   assign ev_end = |hit_e;

   always_comb begin
      if (cfg.pal) begin
         raw_field = ({1'b0, line} >= (LW+1)'(PAL_TOG1));
         at_bnd    = (h == '0) && ((line == LW'(PAL_TOG0)) || (line == LW'(PAL_TOG1)));
      end else begin
         raw_field = !(({1'b0, line} >= (LW+1)'(NTSC_TOG0)) &&
                       ({1'b0, line} <  (LW+1)'(NTSC_TOG1)));
         at_bnd    = (h == '0) && ((line == LW'(NTSC_TOG0)) || (line == LW'(NTSC_TOG1)));
      end
   end
endmodule

// File: rtl/vsf_gen.sv
module vsf_gen import vsf_pkg::*; #(
   parameter int LW            = 10,
   parameter int HS_W          = 64,
   parameter int H_TOT_NTSC    = 858,
   parameter int H_ACT_NTSC    = 720,
   parameter int H_TOT_NTSC_SQ = 780,
   parameter int H_ACT_NTSC_SQ = 640,
   parameter int H_TOT_PAL     = 864,
   parameter int H_ACT_PAL     = 720,
   parameter int H_TOT_PAL_SQ  = 944,
   parameter int H_ACT_PAL_SQ  = 768
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          std_pal_i,
   input  logic          sq_pix_i,
   input  logic [1:0]    vs_beg_ls_i,
   input  logic [1:0]    vs_end_ls_i,
   input  logic          ref_hsb_i,
   input  logic          vs_act_low_i,
   input  logic          shared_vs_i,
   input  logic [LW-1:0] ntsc_vs_beg_i,
   input  logic [LW-1:0] ntsc_vs_end_i,
   input  logic [LW-1:0] pal_vs_beg_i,
   input  logic [LW-1:0] pal_vs_end_i,
   output logic          hs_n_o,
   output logic          vs_o,
   output logic          field_o,
   output logic          shared_o
);
   localparam int H_MAX_A = (H_TOT_NTSC > H_TOT_NTSC_SQ) ? H_TOT_NTSC : H_TOT_NTSC_SQ;
   localparam int H_MAX_B = (H_TOT_PAL  > H_TOT_PAL_SQ)  ? H_TOT_PAL  : H_TOT_PAL_SQ;
   localparam int H_MAX   = (H_MAX_A > H_MAX_B) ? H_MAX_A : H_MAX_B;
   localparam int HW      = $clog2(H_MAX);

   if ((1 << LW) <= PAL_LINES) begin : g_bad_lw
      $error("LW too narrow for line numbers");
   end
   if ((HS_W + H_ACT_NTSC / 2 >= H_TOT_NTSC) || (HS_W + H_ACT_NTSC_SQ / 2 >= H_TOT_NTSC_SQ) ||
       (HS_W + H_ACT_PAL / 2 >= H_TOT_PAL)   || (HS_W + H_ACT_PAL_SQ / 2 >= H_TOT_PAL_SQ)) begin : g_bad_h
      $error("mid-line point falls outside the line");
   end

   vsf_cfg_t      cfg_in, cfg_q;
   logic [LW-1:0] beg_q, end_q;
   logic [HW-1:0] h;
   logic [LW-1:0] line;
   logic          ev_beg, ev_end, raw_field, at_bnd;
   logic          vs_state, vs_nxt, vs_pin, fld_pin, valid;
   logic [1:0]    seen, seen_nxt;

   assign cfg_in = '{pal: std_pal_i, sqp: sq_pix_i, beg_ls: vs_beg_ls_i, end_ls: vs_end_ls_i,
                     ref_hsb: ref_hsb_i, vs_low: vs_act_low_i, sh_vs: shared_vs_i};

   vsf_line_timer #(
      .HW(HW), .LW(LW), .H_TOT_NTSC(H_TOT_NTSC), .H_TOT_NTSC_SQ(H_TOT_NTSC_SQ),
      .H_TOT_PAL(H_TOT_PAL), .H_TOT_PAL_SQ(H_TOT_PAL_SQ)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .pal(cfg_q.pal), .sqp(cfg_q.sqp), .h(h), .line(line)
   );

   vsf_edge_sched #(
      .HW(HW), .LW(LW), .HS_W(HS_W), .H_ACT_NTSC(H_ACT_NTSC), .H_ACT_NTSC_SQ(H_ACT_NTSC_SQ),
      .H_ACT_PAL(H_ACT_PAL), .H_ACT_PAL_SQ(H_ACT_PAL_SQ)
   ) u_sched (
      .h(h), .line(line), .cfg(cfg_q), .beg_line(beg_q), .end_line(end_q),
      .ev_beg(ev_beg), .ev_end(ev_end), .raw_field(raw_field), .at_bnd(at_bnd)
   );

   always_comb begin
      vs_nxt   = ev_beg ? 1'b1 : (ev_end ? 1'b0 : vs_state);
      seen_nxt = (at_bnd && seen != 2'd2) ? seen + 2'd1 : seen;
      vs_pin   = vs_nxt ^ cfg_q.vs_low;
      fld_pin  = valid & raw_field;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= cfg_in;
         beg_q    <= std_pal_i ? pal_vs_beg_i : ntsc_vs_beg_i;
         end_q    <= std_pal_i ? pal_vs_end_i : ntsc_vs_end_i;
         vs_state <= 1'b0;
         seen     <= '0;
         valid    <= 1'b0;
         hs_n_o   <= 1'b1;
         vs_o     <= vs_act_low_i;
         field_o  <= 1'b0;
         shared_o <= shared_vs_i & vs_act_low_i;
      end else begin
         if (at_bnd) begin
            cfg_q <= cfg_in;
            beg_q <= std_pal_i ? pal_vs_beg_i : ntsc_vs_beg_i;
            end_q <= std_pal_i ? pal_vs_end_i : ntsc_vs_end_i;
         end
         vs_state <= vs_nxt;
         seen     <= seen_nxt;
         valid    <= (seen_nxt == 2'd2);
         hs_n_o   <= (h >= HW'(HS_W));
         vs_o     <= vs_pin;
         field_o  <= fld_pin;
         shared_o <= cfg_q.sh_vs ? vs_pin : fld_pin;
      end
   end
endmodule

// File: rtl/vsf_gen_chk.sv
module vsf_gen_chk import vsf_pkg::*; (
   input logic     clk,
   input logic     rst_n,
   input logic     vs_act_low_i,
   input logic     vs_o,
   input logic     field_o,
   input logic     shared_o,
   input logic     at_bnd,
   input vsf_cfg_t cfg_q
);
   a_r12_reset_field: assert property (@(posedge clk) !rst_n |=> !field_o);

   a_r12_reset_vs: assert property (@(posedge clk) !rst_n |=> (vs_o == $past(vs_act_low_i)));

   a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !at_bnd |=> $stable(cfg_q));

   a_r10_shared_src: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (shared_o == ($past(cfg_q.sh_vs) ? vs_o : field_o)));

   a_r2_field_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_o) |-> ($past(at_bnd) || $past(at_bnd, 2)));
endmodule

bind vsf_gen vsf_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .vs_act_low_i(vs_act_low_i), .vs_o(vs_o),
   .field_o(field_o), .shared_o(shared_o), .at_bnd(at_bnd), .cfg_q(cfg_q)
);

// File: tb/tb_vsf_gen.sv
module tb_vsf_gen;
   localparam int LW = 10, HSW = 6;
   localparam int TN = 40, AN = 24, TNS = 36, ANS = 20, TP = 44, AP = 28, TPS = 48, APS = 32;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, pal, sqp, refb, low, shv;
   logic [1:0]    bls, els;
   logic [LW-1:0] nb, ne, pb, pe;
   logic          hs_n, vs, fld, sh;

   vsf_gen #(
      .LW(LW), .HS_W(HSW), .H_TOT_NTSC(TN), .H_ACT_NTSC(AN), .H_TOT_NTSC_SQ(TNS),
      .H_ACT_NTSC_SQ(ANS), .H_TOT_PAL(TP), .H_ACT_PAL(AP), .H_TOT_PAL_SQ(TPS), .H_ACT_PAL_SQ(APS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .std_pal_i(pal), .sq_pix_i(sqp), .vs_beg_ls_i(bls),
      .vs_end_ls_i(els), .ref_hsb_i(refb), .vs_act_low_i(low), .shared_vs_i(shv),
      .ntsc_vs_beg_i(nb), .ntsc_vs_end_i(ne), .pal_vs_beg_i(pb), .pal_vs_end_i(pe),
      .hs_n_o(hs_n), .vs_o(vs), .field_o(fld), .shared_o(sh)
   );

   typedef struct packed {
      logic pal; logic sqp; logic [1:0] bls; logic [1:0] els;
      logic refb; logic low; logic shv; logic [9:0] bl; logic [9:0] el; logic [9:0] run;
   } vec_t;

   // pal sqp bls els ref low sh begin end lines-to-run
   localparam vec_t TAB [5] = '{
      '{1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 10'd4,   10'd7,   10'd528},
      '{1'b1, 1'b1, 2'b11, 2'b00, 1'b1, 1'b1, 1'b1, 10'd2,   10'd5,   10'd630},
      '{1'b0, 1'b1, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 10'd10,  10'd12,  10'd280},
      '{1'b1, 1'b0, 2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 10'd1,   10'd3,   10'd320},
      '{1'b0, 1'b0, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 10'd264, 10'd268, 10'd272}
   };

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model state
   int m_h, m_line, m_seen, n_lines, cyc_n, hs_last, hs_per;
   bit m_vs, m_valid, prev_hs;
   bit c_pal, c_sqp, c_ref, c_low, c_sh;
   bit [1:0] c_bls, c_els;
   int c_bl, c_el;
   int e_cnt[4], e_act[4], e_exp[4];
   string TAGS[4] = '{"R4 R5 R6 R7 R8 R9 R13 vs_o", "R2 R3 field_o", "R10 shared_o", "R1 R8 hs_n_o"};

   function automatic int htot(bit p, bit s);
      return p ? (s ? TPS : TP) : (s ? TNS : TN);
   endfunction
   function automatic int hact(bit p, bit s);
      return p ? (s ? APS : AP) : (s ? ANS : AN);
   endfunction

   task automatic latch_cfg();
      c_pal = pal; c_sqp = sqp; c_bls = bls; c_els = els; c_ref = refb; c_low = low; c_sh = shv;
      c_bl = pal ? int'(pb) : int'(nb);
      c_el = pal ? int'(pe) : int'(ne);
   endtask

   task automatic cmp(input int s, input bit act, input bit exp);
      if (act !== exp) begin
         if (e_cnt[s] == 0) begin e_act[s] = act; e_exp[s] = exp; end
         e_cnt[s]++;
      end
   endtask

   task automatic model_step();
      int tot, refp, mid, nl, half, bo, be, eo, ee;
      bit evb, eve, nvs, raw, xf, xv, bnd;
      tot  = htot(c_pal, c_sqp);
      refp = c_ref ? 0 : HSW;
      mid  = refp + hact(c_pal, c_sqp) / 2;
      nl   = c_pal ? 625 : 525;
      half = c_pal ? 312 : 262;
      bo = c_bl; be = c_bl + half; if (be > nl) be -= nl;
      eo = c_el; ee = c_el + half; if (ee > nl) ee -= nl;
      evb = (m_line == bo && m_h == (c_bls[0] ? refp : mid)) ||
            (m_line == be && m_h == (c_bls[1] ? refp : mid));
      eve = (m_line == eo && m_h == (c_els[0] ? refp : mid)) ||
            (m_line == ee && m_h == (c_els[1] ? refp : mid));
      nvs = evb ? 1'b1 : (eve ? 1'b0 : m_vs);
      raw = c_pal ? (m_line >= 313) : !(m_line >= 4 && m_line < 266);
      xf  = m_valid ? raw : 1'b0;
      xv  = nvs ^ c_low;
      cmp(0, vs, xv);
      cmp(1, fld, xf);
      cmp(2, sh, c_sh ? xv : xf);
      cmp(3, hs_n, m_h >= HSW);
      cyc_n++;
      if (prev_hs && !hs_n) begin
         if (hs_last >= 0 && hs_per < 0) hs_per = cyc_n - hs_last;
         hs_last = cyc_n;
      end
      prev_hs = hs_n;
      bnd = (m_h == 0) && (m_line == (c_pal ? 1 : 4) || m_line == (c_pal ? 313 : 266));
      m_vs = nvs;
      if (bnd) begin
         if (m_seen < 2) m_seen++;
         m_valid = (m_seen >= 2);
         latch_cfg();
      end
      if (m_h == tot - 1) begin
         m_h = 0;
         m_line = (m_line == nl) ? 1 : m_line + 1;
         n_lines++;
      end else m_h++;
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      model_step();
   endtask

   task automatic apply(input vec_t v);
      pal = v.pal; sqp = v.sqp; bls = v.bls; els = v.els; refb = v.refb; low = v.low; shv = v.shv;
      nb = v.pal ? 10'd100 : v.bl; ne = v.pal ? 10'd101 : v.el;
      pb = v.pal ? v.bl : 10'd200; pe = v.pal ? v.el : 10'd201;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(vs === low, "R12 vs_o in reset", vs, low);
      check(fld === 1'b0, "R12 field_o in reset", fld, 0);
      latch_cfg();
      m_h = 0; m_line = 1; m_seen = 0; m_vs = 0; m_valid = 0; n_lines = 0;
      cyc_n = 0; hs_last = -1; hs_per = -1; prev_hs = 1'b1;
      for (int s = 0; s < 4; s++) e_cnt[s] = 0;
      rst_n = 1'b1;
   endtask

   task automatic close_run();
      for (int s = 0; s < 4; s++) check(e_cnt[s] == 0, TAGS[s], e_act[s], e_exp[s]);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog expired actual=0 expected=1");
         finish_up();
      end
   end

   initial begin
      rst_n = 1'b0;
      apply(TAB[0]);
      for (int i = 0; i < 5; i++) begin
         apply(TAB[i]);
         do_reset();
         while (n_lines < int'(TAB[i].run)) cyc();
         close_run();
         check(hs_per == htot(TAB[i].pal, TAB[i].sqp), "R1 line period", hs_per,
               htot(TAB[i].pal, TAB[i].sqp));
      end

      // directed: mid-field change waits for the next boundary (R11), field gate (R3)
      apply(TAB[0]);
      do_reset();
      while (!(m_line == 2 && m_h == 10)) cyc();
      check(fld === 1'b0, "R3 field gated before second boundary", fld, 0);
      while (m_line != 100) cyc();
      low = 1'b1;
      shv = 1'b1;
      while (!(m_line == 150 && m_h == 10)) cyc();
      check(vs === 1'b0, "R11 polarity held until boundary", vs, 0);
      check(sh === 1'b0, "R11 shared select held until boundary", sh, 0);
      while (!(m_line == 280 && m_h == 10)) cyc();
      check(vs === 1'b1, "R11 polarity applied after boundary", vs, 1);
      check(sh === 1'b1, "R11 shared select applied after boundary", sh, 1);
      check(fld === 1'b1, "R2 second field after boundary", fld, 1);
      close_run();
      done = 1;
      finish_up();
   end
endmodule